// File: doc/BRIEF.md
# Sub-word access splitter

This block connects a 32-bit bus master to a register space that accepts only single-byte transfers. The master issues one read or write and gives its width: byte, halfword or word. The splitter first forces the address to the natural alignment of that width. It then plays the access out as a run of byte transfers against a byte-wide backend, one per clock, starting at the lowest offset. For reads it packs the returned bytes into a little-endian, zero-extended 32-bit result.

A small demonstration backend sits inside the block. It holds a few read-write byte cells at the bottom of the address space and one constant 16-bit read-only register at a parameterised address. Every other byte address is unmapped.

The control logic is a three-state machine:
- `ST_IDLE` waits for a request.
- `ST_XFER` issues one byte per cycle.
- `ST_FINISH` raises the one-cycle `done` pulse.

The transitions are:
- IDLE→XFER when a request arrives while idle.
- XFER→XFER while bytes remain.
- XFER→FINISH after the last byte.
- FINISH→IDLE unconditionally.

The byte-side transfers are brought out on the `bb_*` ports so the order of the transfers can be observed.

Top module: `busword_splitter`

## Requirements
- R1: A word access (`req_size` 2'b10, or 2'b11, which is handled as a word) clears address bits [1:0]. It becomes four byte transfers at aligned base +0, +1, +2 and +3.
- R2: A halfword access (`req_size` 2'b01) clears only address bit 0. It becomes two byte transfers, at aligned base +0 and then base +1.
- R3: A byte access (`req_size` 2'b00) becomes one byte transfer at the unmodified address. Only that byte cell changes.
- R4: Byte transfer k (k counted from 0) carries write data bits [8k+7:8k]. On a read, the byte returned by transfer k lands in `rdata` bits [8k+7:8k].
- R5: The byte at `CONST_ADDR` reads 0x00 and the byte at `CONST_ADDR`+1 reads 0x02, so a halfword read there returns 0x00000200. Writes to these bytes have no effect.
- R6: Bytes outside the read-write cells and the constant register read as 0x00, and writes to them are dropped.
- R7: Byte transfers occur on consecutive cycles in ascending address order, starting the cycle after acceptance. `done` is high for exactly one cycle, in the cycle after the last transfer.
- R8: A request is accepted only in `ST_IDLE`. `busy` is high from the cycle after acceptance through the `done` cycle. A request presented while busy is ignored.
- R9: The read result is zero-extended: after a byte read `rdata`[31:8] is 0, and after a halfword read `rdata`[31:16] is 0. A write leaves `rdata` at 0.
- R10: After reset `busy`, `done` and `bb_valid` are 0, `rdata` is 0, and every read-write byte cell holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, little-endian |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled, zero-extended read result |
| bb_valid | output | 1 | Byte transfer issued this cycle |
| bb_write | output | 1 | Byte transfer is a write |
| bb_addr | output | ADDR_W | Byte transfer address |
| bb_wdata | output | 8 | Byte transfer write data |
| bb_rdata | output | 8 | Byte returned by the backend |

## Verification
On every cycle the bound checker watches several properties:
- byte transfers never appear outside a busy sequence;
- consecutive transfers step the address by exactly one;
- the first transfer of a word or halfword sits on its natural boundary;
- `done` is a single pulse preceded by exactly the right number of transfers;
- the constant and unmapped bytes return their fixed values;
- narrow reads are zero-extended.

Only the directed scenarios can show the rest:
- write data actually lands in the intended cells, while neighbouring cells, read-only bytes and unmapped bytes stay unchanged;
- lanes are reassembled in the right order;
- a request that arrives mid-sequence leaves no trace in storage.

// File: rtl/split_pkg.sv
package split_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_XFER   = 2'b01,
        ST_FINISH = 2'b10
    } seq_state_e;

    // number of byte transfers an access of the given width needs
    function automatic logic [2:0] beat_count(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: beat_count = 3'd1;
            SZ_HALF: beat_count = 3'd2;
            default: beat_count = 3'd4;
        endcase
    endfunction

    // address bits cleared to reach natural alignment
    function automatic logic [1:0] align_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: align_mask = 2'b00;
            SZ_HALF: align_mask = 2'b01;
            default: align_mask = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/split_fsm.sv
module split_fsm
    import split_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  bb_valid,
    output logic                  bb_write,
    output logic [ADDR_W-1:0]     bb_addr,
    output logic [7:0]            bb_wdata,
    output logic [$clog2(DATA_W/8)-1:0] beat_idx,
    output logic                  gather_clr
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    seq_state_e          state_q, state_d;
    logic [LANE_W-1:0]   beat_q, last_q;
    logic [ADDR_W-1:0]   base_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                write_q;
    logic                accept;
    logic [ADDR_W-1:0]   aligned;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign aligned = req_addr & ~{{(ADDR_W-2){1'b0}}, align_mask(req_size)};

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_XFER;
            ST_XFER:   if (beat_q == last_q) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            last_q  <= '0;
            beat_q  <= '0;
        end else if (accept) begin
            base_q  <= aligned;
            wdata_q <= req_wdata;
            write_q <= req_write;
            last_q  <= LANE_W'(beat_count(req_size) - 3'd1);
            beat_q  <= '0;
        end else if (state_q == ST_XFER) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        bb_valid   = 1'b0;
        bb_write   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_XFER: begin
                busy     = 1'b1;
                bb_valid = 1'b1;
                bb_write = write_q;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default:   ;
        endcase
        bb_addr    = base_q + {{(ADDR_W-LANE_W){1'b0}}, beat_q};
        bb_wdata   = wdata_q[{beat_q, 3'b000} +: 8];
        beat_idx   = beat_q;
        gather_clr = accept;
    end

endmodule

// File: rtl/byte_backend.sv
module byte_backend #(
    parameter int          ADDR_W     = 12,
    parameter int          RW_BYTES   = 8,
    parameter int          CONST_ADDR = 32,
    parameter logic [15:0] CONST_VAL  = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bb_valid,
    input  logic              bb_write,
    input  logic [ADDR_W-1:0] bb_addr,
    input  logic [7:0]        bb_wdata,
    output logic [7:0]        bb_rdata
);
    localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(CONST_ADDR);
    localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(CONST_ADDR + 1);

    logic [7:0]          cell_q [RW_BYTES];
    logic [RW_BYTES-1:0] hit;
    logic [7:0]          rd;

    // one decoder per read-write cell
    for (genvar g = 0; g < RW_BYTES; g++) begin : g_dec
        assign hit[g] = bb_valid && (bb_addr == ADDR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RW_BYTES; i++) cell_q[i] <= 8'h00;
        end else if (bb_write) begin
            for (int i = 0; i < RW_BYTES; i++)
                if (hit[i]) cell_q[i] <= bb_wdata;
        end
    end

    // read mux: constant bytes and cells, everything else zero
    always_comb begin
        rd = 8'h00;
        for (int i = 0; i < RW_BYTES; i++)
            if (hit[i]) rd = cell_q[i];
        if (bb_addr == C_LO) rd = CONST_VAL[7:0];
        if (bb_addr == C_HI) rd = CONST_VAL[15:8];
        bb_rdata = bb_valid ? rd : 8'h00;
    end

endmodule

// File: rtl/read_gather.sv
module read_gather #(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        cap,
    input  logic [$clog2(DATA_W/8)-1:0] idx,
    input  logic [7:0]                  byte_in,
    output logic [DATA_W-1:0]           word
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] acc_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = cap && (idx == LANE_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else begin
            for (int i = 0; i < LANES; i++)
                if (lane_en[i]) acc_q[i*8 +: 8] <= byte_in;
        end
    end

    assign word = acc_q;

endmodule

// File: rtl/busword_splitter.sv
module busword_splitter #(
    parameter int          ADDR_W     = 12,
    parameter int          RW_BYTES   = 8,
    parameter int          CONST_ADDR = 32,
    parameter logic [15:0] CONST_VAL  = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              bb_valid,
    output logic              bb_write,
    output logic [ADDR_W-1:0] bb_addr,
    output logic [7:0]        bb_wdata,
    output logic [7:0]        bb_rdata
);
    localparam int DATA_W = 32;
    localparam int LANE_W = $clog2(DATA_W / 8);

    logic [LANE_W-1:0] beat_idx;
    logic              gather_clr;

    split_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .done       (done),
        .bb_valid   (bb_valid),
        .bb_write   (bb_write),
        .bb_addr    (bb_addr),
        .bb_wdata   (bb_wdata),
        .beat_idx   (beat_idx),
        .gather_clr (gather_clr)
    );

    byte_backend #(
        .ADDR_W     (ADDR_W),
        .RW_BYTES   (RW_BYTES),
        .CONST_ADDR (CONST_ADDR),
        .CONST_VAL  (CONST_VAL)
    ) u_backend (
        .clk      (clk),
        .rst_n    (rst_n),
        .bb_valid (bb_valid),
        .bb_write (bb_write),
        .bb_addr  (bb_addr),
        .bb_wdata (bb_wdata),
        .bb_rdata (bb_rdata)
    );

    read_gather #(.DATA_W(DATA_W)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gather_clr),
        .cap     (bb_valid && !bb_write),
        .idx     (beat_idx),
        .byte_in (bb_rdata),
        .word    (rdata)
    );

endmodule

// File: rtl/split_checker.sv
module split_checker
    import split_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          RW_BYTES   = 8,
    parameter int          CONST_ADDR = 32,
    parameter logic [15:0] CONST_VAL  = 16'h0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_size,
    input logic              busy,
    input logic              done,
    input logic [31:0]       rdata,
    input logic              bb_valid,
    input logic              bb_write,
    input logic [ADDR_W-1:0] bb_addr,
    input logic [7:0]        bb_rdata
);
    localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(CONST_ADDR);
    localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(CONST_ADDR + 1);

    logic [1:0] sz_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sz_q  <= 2'b00;
            cnt_q <= 3'd0;
        end else if (req_valid && !busy) begin
            sz_q  <= req_size;
            cnt_q <= 3'd0;
        end else if (bb_valid) begin
            cnt_q <= cnt_q + 3'd1;
        end
    end

    assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && cnt_q == 3'd0 && sz_q[1]) |-> (bb_addr[1:0] == 2'b00));

    assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && cnt_q == 3'd0 && sz_q == SZ_HALF) |-> (bb_addr[0] == 1'b0));

    assert_const_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && !bb_write && bb_addr == C_LO) |-> (bb_rdata == CONST_VAL[7:0]));

    assert_const_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && !bb_write && bb_addr == C_HI) |-> (bb_rdata == CONST_VAL[15:8]));

    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && !bb_write && bb_addr >= ADDR_W'(RW_BYTES)
         && bb_addr != C_LO && bb_addr != C_HI) |-> (bb_rdata == 8'h00));

    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && $past(bb_valid)) |-> (bb_addr == $past(bb_addr) + ADDR_W'(1)));

    assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == beat_count(sz_q)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_byte_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bb_valid |-> busy);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_zero_ext_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sz_q == SZ_BYTE) |-> (rdata[31:8] == 24'h0));

    assert_zero_ext_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sz_q == SZ_HALF) |-> (rdata[31:16] == 16'h0));

endmodule

bind busword_splitter split_checker #(
    .ADDR_W     (ADDR_W),
    .RW_BYTES   (RW_BYTES),
    .CONST_ADDR (CONST_ADDR),
    .CONST_VAL  (CONST_VAL)
) u_split_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .bb_valid  (bb_valid),
    .bb_write  (bb_write),
    .bb_addr   (bb_addr),
    .bb_rdata  (bb_rdata)
);

// File: tb/busword_splitter_bench.sv
module busword_splitter_bench;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              busy, done, bb_valid, bb_write;
    logic [31:0]       rdata;
    logic [ADDR_W-1:0] bb_addr;
    logic [7:0]        bb_wdata, bb_rdata;

    int total = 0;
    int bad   = 0;

    logic [ADDR_W-1:0] cap_addr [4];
    logic [7:0]        cap_wd   [4];
    int                cap_n;
    int                cap_lat;
    logic [31:0]       cap_rd;

    always #2 clk = ~clk;

    busword_splitter #(.ADDR_W(ADDR_W)) u_busword_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bb_valid(bb_valid),
        .bb_write(bb_write), .bb_addr(bb_addr), .bb_wdata(bb_wdata),
        .bb_rdata(bb_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // run one access; record byte transfers, latency and result
    task automatic run(input logic wr, input logic [1:0] sz,
                       input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                       input logic intrude);
        int j;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        if (intrude) begin
            req_write = 1'b1; req_size = 2'b01;
            req_addr = 12'h004; req_wdata = 32'h0000_9999;
        end else begin
            req_valid = 1'b0;
        end
        cap_n = 0; cap_lat = -1; j = 0;
        while (j < 12) begin
            if (intrude && j == 2) req_valid = 1'b0;
            check("R8", "busy during sequence", {31'd0, busy}, 32'd1);
            if (bb_valid) begin
                if (cap_n < 4) begin
                    cap_addr[cap_n] = bb_addr;
                    cap_wd[cap_n]   = bb_wdata;
                end
                cap_n++;
            end else if (done) begin
                cap_lat = j;
                cap_rd  = rdata;
                break;
            end
            @(negedge clk);
            j++;
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R7", "done is one pulse", {31'd0, done}, 32'd0);
        check("R8", "idle after done", {31'd0, busy}, 32'd0);
    endtask

    // access plus sequencing checks derived from the width rules
    task automatic access(input string req, input logic wr, input logic [1:0] sz,
                          input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                          input logic intrude);
        int n;
        logic [ADDR_W-1:0] base;
        n    = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        base = (sz == 2'b00) ? addr : (sz == 2'b01) ? (addr & ~12'h001) : (addr & ~12'h003);
        run(wr, sz, addr, wd, intrude);
        check("R7", {req, " byte count"}, cap_n, n);
        check("R7", {req, " done latency"}, cap_lat, n);
        for (int k = 0; k < n && k < 4; k++) begin
            check(req, "byte address order", {20'd0, cap_addr[k]}, {20'd0, base + ADDR_W'(k)});
            if (wr) check("R4", "byte lane data", {24'd0, cap_wd[k]}, {24'd0, wd[k*8 +: 8]});
        end
        if (wr) check("R9", "rdata after write", cap_rd, 32'd0);
    endtask

    task automatic read_expect(input string req, input logic [1:0] sz,
                               input logic [ADDR_W-1:0] addr, input logic [31:0] exp);
        access(req, 1'b0, sz, addr, 32'd0, 1'b0);
        check(req, "read result", cap_rd, exp);
    endtask

    task automatic t_reset;
        check("R10", "busy after reset", {31'd0, busy}, 32'd0);
        check("R10", "done after reset", {31'd0, done}, 32'd0);
        check("R10", "bb_valid after reset", {31'd0, bb_valid}, 32'd0);
        check("R10", "rdata after reset", rdata, 32'd0);
        read_expect("R10", 2'b10, 12'h000, 32'd0);
        read_expect("R10", 2'b10, 12'h004, 32'd0);
    endtask

    task automatic t_word;
        access("R1", 1'b1, 2'b10, 12'h003, 32'hA1B2_C3D4, 1'b0);
        read_expect("R1", 2'b10, 12'h001, 32'hA1B2_C3D4);
        read_expect("R4", 2'b10, 12'h000, 32'hA1B2_C3D4);
    endtask

    task automatic t_half;
        read_expect("R2", 2'b01, 12'h003, 32'h0000_A1B2);
        access("R2", 1'b1, 2'b01, 12'h005, 32'hFFFF_1234, 1'b0);
        read_expect("R4", 2'b10, 12'h004, 32'h0000_1234);
        read_expect("R9", 2'b01, 12'h004, 32'h0000_1234);
    endtask

    task automatic t_byte;
        read_expect("R3", 2'b00, 12'h005, 32'h0000_0012);
        access("R3", 1'b1, 2'b00, 12'h007, 32'hFFFF_FF5A, 1'b0);
        read_expect("R3", 2'b10, 12'h004, 32'h5A00_1234);
        read_expect("R9", 2'b00, 12'h002, 32'h0000_00B2);
    endtask

    task automatic t_const;
        read_expect("R5", 2'b01, 12'h020, 32'h0000_0200);
        read_expect("R5", 2'b00, 12'h021, 32'h0000_0002);
        read_expect("R5", 2'b00, 12'h020, 32'h0000_0000);
        read_expect("R5", 2'b01, 12'h021, 32'h0000_0200);
        access("R5", 1'b1, 2'b10, 12'h020, 32'hFFFF_FFFF, 1'b0);
        read_expect("R5", 2'b10, 12'h020, 32'h0000_0200);
    endtask

    task automatic t_unmapped;
        access("R6", 1'b1, 2'b10, 12'h100, 32'hDEAD_BEEF, 1'b0);
        read_expect("R6", 2'b10, 12'h100, 32'd0);
        read_expect("R6", 2'b00, 12'h008, 32'd0);
        read_expect("R6", 2'b10, 12'h000, 32'hA1B2_C3D4);
        read_expect("R6", 2'b10, 12'h004, 32'h5A00_1234);
    endtask

    task automatic t_busy_ignore;
        access("R8", 1'b1, 2'b10, 12'h000, 32'h1111_1111, 1'b1);
        read_expect("R8", 2'b10, 12'h004, 32'h5A00_1234);
        read_expect("R8", 2'b10, 12'h000, 32'h1111_1111);
    endtask

    task automatic t_size3;
        read_expect("R1", 2'b11, 12'h006, 32'h5A00_1234);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_word;
        t_half;
        t_byte;
        t_const;
        t_unmapped;
        t_busy_ignore;
        t_size3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule